// File: doc/BRIEF.md
# Block-Partitioned Power-Gated SRAM

This block is a word-addressed on-chip memory divided into a parameterised number of independent sub-blocks that share one global read-data bus. Each incoming address is split into three fields: a block field that picks the sub-block, a row field and a column field. An accepted access wakes only the chosen sub-block. Every other sub-block stays in a retention state, with its local row decoder, column decoder and sense path disabled and its stored words kept.

A global `sleep` input places the whole array in data-retention mode. While it is high, no sub-block is enabled and requests have no effect. Each request that arrives during sleep is reported with a one-cycle error pulse. The local enables stand in for the analog sense, precharge and supply-switch controls.

Reads return through a registered path: the word and a valid strobe appear one cycle after the request. When no read result is due, the global bus drives zero.

Top module: `bsram_pgated`

## Requirements
- R1: The address is laid out as {block, row, column}, with the block field in the most significant bits and the column in the least significant bits (defaults: bits 7:6, 5:2 and 1:0). Each distinct address holds its own word.
- R2: In the same cycle as an accepted request (`req_valid` high, `sleep` low), `blk_active` has exactly one bit set, at the index given by the block field. With no accepted request, `blk_active` is all zero.
- R3: For every sub-block that is not addressed, `row_dec_en`, `col_dec_en` and `sense_en` are low. The addressed sub-block raises both decoder enables for reads and writes, and raises `sense_en` only for a read.
- R4: A write changes only the addressed word of the addressed sub-block. Neighbouring words and the same row and column position in other sub-blocks are unchanged.
- R5: While `sleep` is high, all enables and `blk_active` are zero and requests have no effect (a write changes nothing). Stored contents survive sleep.
- R6: A read accepted in cycle n gives `rd_valid` high with `rd_data` equal to the stored word in cycle n+1. Writes never raise `rd_valid`.
- R7: A request made while `sleep` is high raises `sleep_err` in the following cycle, for one cycle per such request. Otherwise `sleep_err` is low.
- R8: `rd_data` is zero whenever `rd_valid` is low.
- R9: During reset, and until the first request after reset, `rd_valid` and `sleep_err` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | BLK_W+ROW_W+COL_W (8) | Address {block, row, column} |
| req_wdata | input | DATA_W (8) | Write data |
| sleep | input | 1 | Global retention mode |
| rd_data | output | DATA_W (8) | Global read bus |
| rd_valid | output | 1 | Read result strobe |
| blk_active | output | NUM_BLK (4) | Per-sub-block active status |
| row_dec_en | output | NUM_BLK (4) | Per-sub-block row decoder enable |
| col_dec_en | output | NUM_BLK (4) | Per-sub-block column decoder enable |
| sense_en | output | NUM_BLK (4) | Per-sub-block sense enable |
| sleep_err | output | 1 | Request-during-sleep pulse |

## Verification
The status vector and the three enable vectors are combinational and are due in the same cycle as the request. The bench therefore samples them one time unit after it drives the inputs, before the clock edge. `rd_valid`, `rd_data` and `sleep_err` each come from one register stage and are due one cycle later, so the bench compares them at the falling edge after the capturing rising edge against values its model worked out when the request was issued. Every clock cycle is such a step, so idle cycles, sleep cycles and back-to-back accesses are all compared.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  // Per-sub-block operating mode produced by the address decoder.
  typedef enum logic [1:0] {
    BLK_RETAIN = 2'd0,
    BLK_READ   = 2'd1,
    BLK_WRITE  = 2'd2
  } blk_mode_e;
endpackage

// File: rtl/bsram_rst_sync.sv
module bsram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  assign sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/bsram_blk_dec.sv
module bsram_blk_dec
  import bsram_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 2,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int ADDR_W = BLK_W + ROW_W + COL_W
) (
  input  logic                    ready,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       req_addr,
  output blk_mode_e [NUM_BLK-1:0] blk_mode,
  output logic [ROW_W-1:0]        row_idx,
  output logic [COL_W-1:0]        col_idx,
  output logic                    sleep_hit
);
  logic [BLK_W-1:0] blk_f;
  logic             accept;

  assign {blk_f, row_idx, col_idx} = req_addr;
  assign accept    = ready & req_valid & ~sleep;
  assign sleep_hit = ready & req_valid & sleep;

  always_comb begin
    for (int b = 0; b < NUM_BLK; b++) begin
      blk_mode[b] = BLK_RETAIN;
      if (accept && (blk_f == BLK_W'(b)))
        blk_mode[b] = req_we ? BLK_WRITE : BLK_READ;
    end
  end
endmodule

// File: rtl/bsram_bank.sv
module bsram_bank
  import bsram_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 4,
  parameter int DATA_W = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int WORDS = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  blk_mode_e         mode,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [COL_W-1:0]  col_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              row_dec_en,
  output logic              col_dec_en,
  output logic              sense_en,
  output logic [DATA_W-1:0] rd_q
);
  logic [ROWS-1:0]   row_line;
  logic [COLS-1:0]   col_line;
  logic [WORDS-1:0]  cell_hit;
  logic              wr_en;
  logic [DATA_W-1:0] cell_q [WORDS];
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_r;

  // Local power-state controls: everything off while retaining.
  assign row_dec_en = (mode != BLK_RETAIN);
  assign col_dec_en = (mode != BLK_RETAIN);
  assign sense_en   = (mode == BLK_READ);
  assign wr_en      = (mode == BLK_WRITE);

  // Local row and column decoders, gated by their enables.
  always_comb begin
    row_line = '0;
    if (row_dec_en) row_line[row_idx] = 1'b1;
  end

  always_comb begin
    col_line = '0;
    if (col_dec_en) col_line[col_idx] = 1'b1;
  end

  always_comb begin
    for (int w = 0; w < WORDS; w++)
      cell_hit[w] = row_line[w / COLS] & col_line[w % COLS];
  end

  // Storage cells, no reset (retention array).
  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++)
      if (wr_en && cell_hit[w]) cell_q[w] <= wdata;
  end

  // Sense path next state.
  always_comb begin
    rd_d = '0;
    for (int w = 0; w < WORDS; w++)
      if (cell_hit[w]) rd_d = rd_d | cell_q[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_r <= '0;
    else if (sense_en) rd_r <= rd_d;
  end

  assign rd_q = rd_r;
endmodule

// File: rtl/bsram_gbus.sv
module bsram_gbus
  import bsram_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int DATA_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  blk_mode_e [NUM_BLK-1:0]        blk_mode,
  input  logic [NUM_BLK-1:0][DATA_W-1:0] bank_q,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           rd_valid
);
  logic [NUM_BLK-1:0] rsel_d;
  logic [NUM_BLK-1:0] rsel_q;

  always_comb begin
    for (int b = 0; b < NUM_BLK; b++)
      rsel_d[b] = (blk_mode[b] == BLK_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsel_q <= '0;
    else        rsel_q <= rsel_d;
  end

  assign rd_valid = |rsel_q;

  // Global driver: AND-OR of the bank registers, zero when nothing selected.
  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NUM_BLK; b++)
      if (rsel_q[b]) rd_data = rd_data | bank_q[b];
  end
endmodule

// File: rtl/bsram_pgated.sv
module bsram_pgated
  import bsram_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int ROWS    = 16,
  parameter int COLS    = 4,
  parameter int DATA_W  = 8,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = BLK_W + ROW_W + COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               sleep,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic [NUM_BLK-1:0] blk_active,
  output logic [NUM_BLK-1:0] row_dec_en,
  output logic [NUM_BLK-1:0] col_dec_en,
  output logic [NUM_BLK-1:0] sense_en,
  output logic               sleep_err
);
  logic                           rst_sync_n;
  blk_mode_e [NUM_BLK-1:0]        blk_mode;
  logic [ROW_W-1:0]               row_idx;
  logic [COL_W-1:0]               col_idx;
  logic                           sleep_hit;
  logic [NUM_BLK-1:0][DATA_W-1:0] bank_q;
  logic                           err_d;
  logic                           err_q;

  bsram_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  bsram_blk_dec #(
    .NUM_BLK(NUM_BLK), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_dec (
    .ready    (rst_sync_n),
    .req_valid(req_valid),
    .req_we   (req_we),
    .sleep    (sleep),
    .req_addr (req_addr),
    .blk_mode (blk_mode),
    .row_idx  (row_idx),
    .col_idx  (col_idx),
    .sleep_hit(sleep_hit)
  );

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_bank
    bsram_bank #(
      .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .mode      (blk_mode[b]),
      .row_idx   (row_idx),
      .col_idx   (col_idx),
      .wdata     (req_wdata),
      .row_dec_en(row_dec_en[b]),
      .col_dec_en(col_dec_en[b]),
      .sense_en  (sense_en[b]),
      .rd_q      (bank_q[b])
    );
    assign blk_active[b] = (blk_mode[b] != BLK_RETAIN);
  end

  bsram_gbus #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_gbus (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .blk_mode(blk_mode),
    .bank_q  (bank_q),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  // Sleep-access error pulse.
  assign err_d = sleep_hit;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign sleep_err = err_q;
endmodule

// File: rtl/bsram_pgated_chk.sv
module bsram_pgated_chk #(
  parameter int NUM_BLK = 4,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_we,
  input logic               sleep,
  input logic [NUM_BLK-1:0] blk_active,
  input logic [NUM_BLK-1:0] row_dec_en,
  input logic [NUM_BLK-1:0] col_dec_en,
  input logic [NUM_BLK-1:0] sense_en,
  input logic [DATA_W-1:0]  rd_data,
  input logic               rd_valid,
  input logic               sleep_err
);
  assert_one_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sleep) |-> ($countones(blk_active) == 1));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (blk_active == '0));

  assert_unaddressed_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (((row_dec_en | col_dec_en | sense_en) & ~blk_active) == '0));

  assert_sleep_all_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> ((blk_active | row_dec_en | col_dec_en | sense_en) == '0));

  assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !sleep) |=> rd_valid);

  assert_write_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we && !sleep) |=> !rd_valid);

  assert_sleep_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sleep) |=> sleep_err);

  assert_no_spurious_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && sleep) |=> !sleep_err);

  assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));
endmodule

bind bsram_pgated bsram_pgated_chk #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_we    (req_we),
  .sleep     (sleep),
  .blk_active(blk_active),
  .row_dec_en(row_dec_en),
  .col_dec_en(col_dec_en),
  .sense_en  (sense_en),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .sleep_err (sleep_err)
);

// File: tb/bsram_pgated_tb_top.sv
module bsram_pgated_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB    = 4;
  localparam int ROWS  = 16;
  localparam int COLS  = 4;
  localparam int DW    = 8;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int AW    = $clog2(NB) + ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_we, sleep;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [DW-1:0] rd_data;
  logic          rd_valid, sleep_err;
  logic [NB-1:0] blk_active, row_dec_en, col_dec_en, sense_en;

  int vec_cnt  = 0;
  int miss_cnt = 0;
  logic [DW-1:0] mdl [DEPTH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  bsram_pgated #(.NUM_BLK(NB), .ROWS(ROWS), .COLS(COLS), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .sleep(sleep),
    .rd_data(rd_data), .rd_valid(rd_valid), .blk_active(blk_active),
    .row_dec_en(row_dec_en), .col_dec_en(col_dec_en), .sense_en(sense_en),
    .sleep_err(sleep_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      miss_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  endtask

  // One clock of stimulus; called at a falling edge, returns at the next one.
  task automatic step(input logic v, input logic we, input int addr, input int wd,
                      input logic slp, input string tag);
    logic [NB-1:0] e_act, e_sense;
    logic          e_rv, e_err;
    logic [DW-1:0] e_rd;
    int            blk;
    req_valid = v; req_we = we; req_addr = addr[AW-1:0];
    req_wdata = wd[DW-1:0]; sleep = slp;
    #1;
    blk     = addr >> (ROW_W + COL_W);
    e_act   = (v && !slp) ? (NB'(1) << blk) : '0;
    e_sense = (v && !slp && !we) ? e_act : '0;
    chk({tag, " R2 blk_active"}, 64'(blk_active), 64'(e_act));
    chk({tag, " R3 row_dec_en"}, 64'(row_dec_en), 64'(e_act));
    chk({tag, " R3 col_dec_en"}, 64'(col_dec_en), 64'(e_act));
    chk({tag, " R3 sense_en"},   64'(sense_en),   64'(e_sense));
    e_rv  = v && !slp && !we;
    e_rd  = e_rv ? mdl[addr] : '0;
    e_err = v && slp;
    if (v && !slp && we) mdl[addr] = wd[DW-1:0];
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R6 rd_valid"}, 64'(rd_valid), 64'(e_rv));
    chk(e_rv ? {tag, " R6 rd_data"} : {tag, " R8 rd_data idle"}, 64'(rd_data), 64'(e_rd));
    chk({tag, " R7 sleep_err"}, 64'(sleep_err), 64'(e_err));
    req_valid = 1'b0;
  endtask

  function automatic int pat(input int a);
    return (a * 37 + 11) & 8'hFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miss_cnt++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int tgt;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; sleep = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset rd_valid",  64'(rd_valid),  64'd0);
    chk("R9 reset rd_data",   64'(rd_data),   64'd0);
    chk("R9 reset sleep_err", 64'(sleep_err), 64'd0);
    chk("R9 reset blk_active", 64'(blk_active), 64'd0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 0, 0, 1'b0, "R9 post-reset idle");

    // R1: fill every address with a distinct pattern, then read all back.
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b1, a, pat(a), 1'b0, "R1 fill");
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, a, 0, 1'b0, "R1 readback");

    // R4: one write, check neighbours and the same slot in the other blocks.
    tgt = (1 << (ROW_W + COL_W)) | (5 << COL_W) | 2;
    step(1'b1, 1'b1, tgt, 8'hC3, 1'b0, "R4 write");
    step(1'b1, 1'b0, tgt, 0, 1'b0, "R4 target");
    step(1'b1, 1'b0, tgt - 1, 0, 1'b0, "R4 left");
    step(1'b1, 1'b0, tgt + 1, 0, 1'b0, "R4 right");
    step(1'b1, 1'b0, tgt - COLS, 0, 1'b0, "R4 row above");
    for (int b = 0; b < NB; b++)
      step(1'b1, 1'b0, (tgt & ((1 << (ROW_W + COL_W)) - 1)) | (b << (ROW_W + COL_W)),
           0, 1'b0, "R4 other block");

    // R5 / R7: sleep blocks requests, keeps contents.
    step(1'b0, 1'b0, 0, 0, 1'b1, "R5 sleep idle");
    step(1'b1, 1'b1, tgt, 8'h5A, 1'b1, "R5 sleep write");
    step(1'b1, 1'b0, tgt, 0, 1'b1, "R5 sleep read");
    step(1'b1, 1'b1, 3, 8'h00, 1'b1, "R7 sleep write b0");
    step(1'b1, 1'b1, 4, 8'h00, 1'b1, "R7 back-to-back");
    repeat (4) step(1'b0, 1'b0, 0, 0, 1'b1, "R5 sleep hold");
    step(1'b0, 1'b0, 0, 0, 1'b0, "R7 wake idle");
    step(1'b1, 1'b0, tgt, 0, 1'b0, "R5 retained");
    step(1'b1, 1'b0, 3, 0, 1'b0, "R5 retained b0");
    step(1'b1, 1'b0, 4, 0, 1'b0, "R5 retained b0 next");

    // R6: write then immediate read, alternating blocks, idle gaps.
    for (int k = 0; k < 8; k++) begin
      int a;
      a = ((k % NB) << (ROW_W + COL_W)) | (k * 5 % (ROWS * COLS));
      step(1'b1, 1'b1, a, 8'hA0 + k, 1'b0, "R6 write");
      step(1'b1, 1'b0, a, 0, 1'b0, "R6 read after write");
      if (k % 2 == 1) step(1'b0, 1'b0, 0, 0, 1'b0, "R8 gap");
    end
    for (int k = 0; k < 12; k++)
      step(1'b1, 1'b0, (k * 23) % DEPTH, 0, 1'b0, "R6 streamed reads");
    step(1'b0, 1'b0, 0, 0, 1'b0, "R8 final idle");

    summary();
  end
endmodule